// File: doc/BRIEF.md
# Bidirectional Round-Key Scheduler for an 80-bit-Key Lightweight Cipher

This block produces round keys for a 64-bit-block substitution-permutation cipher with an 80-bit key. It holds the full 80-bit key register and a 5-bit round counter. In forward mode it steps the register through the encryption schedule. In inverse mode it walks the same schedule backwards from the final-round key. Decryption can therefore regenerate round keys on the fly and needs no stored table.

The surrounding logic first pulses `load_i` with a key and a direction. It then pulses `step_i` once per round. After each register update the current 64-bit round key is on `round_key_o`. The counter value the next update will use is on `round_num_o`. `done_o` rises once the whole 31-update schedule has been taken.

Each inverse update runs the forward operations in the opposite order, so it exactly undoes the forward update that used the same counter value. The block does not derive the final-round key from the user key; the caller supplies it.

Top module: `ks80_sched`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no load, `round_key_o` is 0, `round_num_o` is 0 and `done_o` is 0.
- R2: One cycle after `load_i` is sampled high, the key register holds `key_i` and `round_key_o` equals `key_i[79:16]`. `done_o` is 0. `round_num_o` is 1 when `dir_i` was 0 (forward) and 31 when `dir_i` was 1 (inverse). The direction is latched at load.
- R3: A forward update with counter value c turns key K into a new key in three steps. First, K is rotated left by 61 (R = {K[18:0], K[79:19]}). Next, R[79:76] is replaced with S(R[79:76]). Finally, c is XORed into bits [19:15].
- R4: An inverse update with counter value c takes three steps. First, K[79:76] is replaced with S⁻¹(K[79:76]). Next, c is XORed into bits [19:15]. Finally, the 80-bit result T is rotated right by 61, giving {T[60:0], T[79:61]}.
- R5: Each accepted step uses the current `round_num_o` as c. The counter then increments in forward mode and decrements in inverse mode, modulo 32, so it reads 0 once the schedule ends.
- R6: `done_o` rises one cycle after the 31st accepted step. While `done_o` is high, `step_i` has no effect on `round_key_o`, `round_num_o` or `done_o`.
- R7: Run 31 forward steps from key K. Then load the resulting 80-bit key in inverse mode and run 31 inverse steps. The register returns to K, so `round_key_o` equals K[79:16].
- R8: The S-box S maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. S⁻¹ is its exact inverse.
- R9: When `load_i` and `step_i` are both high, the load takes effect and no update is applied.
- R10: A cycle with neither `load_i` nor `step_i` leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture `key_i` and restart the schedule in direction `dir_i` |
| key_i | input | 80 | User key (forward) or final-round key (inverse) |
| dir_i | input | 1 | 0 = forward schedule, 1 = inverse schedule; sampled with `load_i` |
| step_i | input | 1 | Advance one round |
| round_key_o | output | 64 | Current round key, key register bits [79:16] |
| round_num_o | output | 5 | Counter value the next update uses |
| done_o | output | 1 | All 31 updates taken |

## Verification
All three outputs are registered. A load or step sampled at a rising edge is visible on every output right after that edge, with a latency of one cycle. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so every expectation lines up with exactly one accepted update.

The bench model holds the full 80-bit key. It is advanced with the forward and inverse equations rebuilt from the S-box listing, and the inverse S-box is found by searching that listing. The bench sweeps full forward and inverse schedules over many keys, including all-zeros and all-ones. Idle cycles, extra steps after completion and load-with-step collisions are each checked on the cycle after they are applied.

// File: rtl/ks80_pkg.sv
package ks80_pkg;
  localparam int KEY_W  = 80;
  localparam int CNT_W  = 5;
  localparam int NIB_W  = 4;
  localparam int RK_W   = 64;
  localparam int ROT    = 61;
  localparam int CTR_LO = 15;
  localparam int ROUNDS = 31;

  typedef logic [KEY_W-1:0] key_t;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_INV = 1'b1
  } dir_e;
endpackage

// File: rtl/ks80_sbox.sv
module ks80_sbox
  import ks80_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  nib_t nib_i,
  output nib_t nib_o
);
  generate
    if (INVERSE) begin : g_inv
      always_comb begin
        unique case (nib_i)
          4'h0: nib_o = 4'h5;
          4'h1: nib_o = 4'hE;
          4'h2: nib_o = 4'hF;
          4'h3: nib_o = 4'h8;
          4'h4: nib_o = 4'hC;
          4'h5: nib_o = 4'h1;
          4'h6: nib_o = 4'h2;
          4'h7: nib_o = 4'hD;
          4'h8: nib_o = 4'hB;
          4'h9: nib_o = 4'h4;
          4'hA: nib_o = 4'h6;
          4'hB: nib_o = 4'h3;
          4'hC: nib_o = 4'h0;
          4'hD: nib_o = 4'h7;
          4'hE: nib_o = 4'h9;
          default: nib_o = 4'hA;
        endcase
      end
    end else begin : g_fwd
      always_comb begin
        unique case (nib_i)
          4'h0: nib_o = 4'hC;
          4'h1: nib_o = 4'h5;
          4'h2: nib_o = 4'h6;
          4'h3: nib_o = 4'hB;
          4'h4: nib_o = 4'h9;
          4'h5: nib_o = 4'h0;
          4'h6: nib_o = 4'hA;
          4'h7: nib_o = 4'hD;
          4'h8: nib_o = 4'h3;
          4'h9: nib_o = 4'hE;
          4'hA: nib_o = 4'hF;
          4'hB: nib_o = 4'h8;
          4'hC: nib_o = 4'h4;
          4'hD: nib_o = 4'h7;
          4'hE: nib_o = 4'h1;
          default: nib_o = 4'h2;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/ks80_update.sv
module ks80_update
  import ks80_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  key_t key_i,
  input  cnt_t cnt_i,
  output key_t key_o
);
  localparam int NIB_LO = KEY_W - NIB_W;

  nib_t sb_in, sb_out;
  key_t mix;

  ks80_sbox #(.INVERSE(INVERSE)) u_sbox (.nib_i(sb_in), .nib_o(sb_out));

  generate
    if (INVERSE) begin : g_inv
      // substitute + counter first, rotate right last
      always_comb begin
        sb_in = key_i[KEY_W-1:NIB_LO];
        mix   = key_i;
        mix[KEY_W-1:NIB_LO] = sb_out;
        mix[CTR_LO+CNT_W-1:CTR_LO] = mix[CTR_LO+CNT_W-1:CTR_LO] ^ cnt_i;
        key_o = (mix >> ROT) | (mix << (KEY_W - ROT));
      end
    end else begin : g_fwd
      // rotate left first, then substitute + counter
      always_comb begin
        mix   = (key_i << ROT) | (key_i >> (KEY_W - ROT));
        sb_in = mix[KEY_W-1:NIB_LO];
        key_o = mix;
        key_o[KEY_W-1:NIB_LO] = sb_out;
        key_o[CTR_LO+CNT_W-1:CTR_LO] = mix[CTR_LO+CNT_W-1:CTR_LO] ^ cnt_i;
      end
    end
  endgenerate
endmodule

// File: rtl/ks80_round_ctr.sv
module ks80_round_ctr
  import ks80_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  dir_e dir_i,
  input  logic adv_i,
  input  dir_e dir_q_i,
  output cnt_t cnt_o,
  output logic done_o
);
  localparam int STEP_W = $clog2(ROUNDS + 1);
  localparam cnt_t FIRST_FWD = cnt_t'(1);
  localparam cnt_t FIRST_INV = cnt_t'(ROUNDS);

  logic [STEP_W-1:0] steps_q;
  cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      steps_q <= '0;
    end else if (load_i) begin
      cnt_q   <= (dir_i == DIR_INV) ? FIRST_INV : FIRST_FWD;
      steps_q <= '0;
    end else if (adv_i) begin
      cnt_q   <= (dir_q_i == DIR_INV) ? cnt_q - cnt_t'(1) : cnt_q + cnt_t'(1);
      steps_q <= steps_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = (steps_q == STEP_W'(ROUNDS));
endmodule

// File: rtl/ks80_sched.sv
module ks80_sched
  import ks80_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              dir_i,
  input  logic              step_i,
  output logic [RK_W-1:0]   round_key_o,
  output logic [CNT_W-1:0]  round_num_o,
  output logic              done_o
);
  key_t key_q, key_fwd, key_inv;
  dir_e dir_q;
  cnt_t cnt;
  logic done, adv;

  assign adv = step_i && !load_i && !done;

  ks80_update #(.INVERSE(1'b0)) u_upd_fwd (.key_i(key_q), .cnt_i(cnt), .key_o(key_fwd));
  ks80_update #(.INVERSE(1'b1)) u_upd_inv (.key_i(key_q), .cnt_i(cnt), .key_o(key_inv));

  ks80_round_ctr u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .dir_i  (dir_e'(dir_i)),
    .adv_i  (adv),
    .dir_q_i(dir_q),
    .cnt_o  (cnt),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      dir_q <= DIR_FWD;
    end else if (load_i) begin
      key_q <= key_i;
      dir_q <= dir_e'(dir_i);
    end else if (adv) begin
      key_q <= (dir_q == DIR_INV) ? key_inv : key_fwd;
    end
  end

  assign round_key_o = key_q[KEY_W-1:KEY_W-RK_W];
  assign round_num_o = cnt;
  assign done_o      = done;
endmodule

// File: rtl/ks80_sched_chk.sv
module ks80_sched_chk
  import ks80_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             dir_i,
  input logic             step_i,
  input logic [RK_W-1:0]  round_key_o,
  input logic [CNT_W-1:0] round_num_o,
  input logic             done_o,
  input logic             dir_q
);
  a_r2_load_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !dir_i |=> round_num_o == 5'd1 && !done_o);

  a_r2_load_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && dir_i |=> round_num_o == 5'd31 && !done_o);

  a_r5_fwd_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !done_o && !dir_q |=> round_num_o == 5'($past(round_num_o) + 5'd1));

  a_r5_inv_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !done_o && dir_q |=> round_num_o == 5'($past(round_num_o) - 5'd1));

  a_r6_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> done_o && $stable(round_key_o) && $stable(round_num_o));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !step_i |=> $stable(round_key_o) && $stable(round_num_o) && $stable(done_o));
endmodule

bind ks80_sched ks80_sched_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .dir_i      (dir_i),
  .step_i     (step_i),
  .round_key_o(round_key_o),
  .round_num_o(round_num_o),
  .done_o     (done_o),
  .dir_q      (dir_q)
);

// File: tb/ks80_sched_tb.sv
module ks80_sched_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [79:0] key_i = '0;
  logic        dir_i = 1'b0;
  logic        step_i = 1'b0;
  logic [63:0] round_key_o;
  logic [4:0]  round_num_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ks80_sched u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .key_i(key_i), .dir_i(dir_i),
    .step_i(step_i), .round_key_o(round_key_o), .round_num_o(round_num_o), .done_o(done_o)
  );

  // R8 listing
  function automatic logic [3:0] sb(input logic [3:0] x);
    logic [63:0] t = 64'hC56B90AD3EF84712;
    return t[63-4*x -: 4];
  endfunction

  function automatic logic [3:0] sb_inv(input logic [3:0] y);
    for (int v = 0; v < 16; v++) if (sb(4'(v)) == y) return 4'(v);
    return 4'h0;
  endfunction

  function automatic logic [79:0] m_fwd(input logic [79:0] k, input logic [4:0] c);
    logic [79:0] r = {k[18:0], k[79:19]};
    r[79:76] = sb(r[79:76]);
    r[19:15] = r[19:15] ^ c;
    return r;
  endfunction

  function automatic logic [79:0] m_inv(input logic [79:0] k, input logic [4:0] c);
    logic [79:0] t = k;
    t[79:76] = sb_inv(t[79:76]);
    t[19:15] = t[19:15] ^ c;
    return {t[60:0], t[79:61]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit ld, input bit st, input bit d, input logic [79:0] k);
    @(negedge clk);
    load_i = ld; step_i = st; dir_i = d; key_i = k;
    @(posedge clk);
    #1;
    load_i = 1'b0; step_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<200000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [79:0] orig, mk;
    #5;
    chk(round_key_o == '0 && round_num_o == '0 && !done_o, "R1 in reset", {round_key_o, 11'd0, round_num_o}, '0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk(round_key_o == '0 && round_num_o == '0 && !done_o, "R1 after release", {round_key_o, 11'd0, round_num_o}, '0);

    for (int t = 0; t < 24; t++) begin
      orig = (t == 0) ? '0 : (t == 1) ? '1 : {$urandom, $urandom, 16'($urandom)};
      mk = orig;
      cyc(1, 0, 0, orig);
      chk(round_key_o == orig[79:16], "R2 fwd load key", 80'(round_key_o), 80'(orig[79:16]));
      chk(round_num_o == 5'd1 && !done_o, "R2 fwd load num", 80'(round_num_o), 80'd1);
      for (int r = 1; r <= 31; r++) begin
        if (t[0] && r == 10) begin
          cyc(0, 0, 1, '1);
          chk(round_key_o == mk[79:16] && round_num_o == 5'(r), "R10 idle hold", 80'(round_key_o), 80'(mk[79:16]));
        end
        mk = m_fwd(mk, 5'(r));
        cyc(0, 1, t[1], '0);
        chk(round_key_o == mk[79:16], "R3 R8 fwd round key", 80'(round_key_o), 80'(mk[79:16]));
        chk(round_num_o == 5'(r + 1), "R5 fwd counter", 80'(round_num_o), 80'(5'(r + 1)));
        chk(done_o == (r == 31), "R6 done", 80'(done_o), 80'(r == 31));
      end
      cyc(0, 1, 0, '0);
      chk(round_key_o == mk[79:16] && round_num_o == 5'd0 && done_o, "R6 step ignored when done", 80'(round_key_o), 80'(mk[79:16]));

      cyc(1, 0, 1, mk);
      chk(round_key_o == mk[79:16] && !done_o, "R2 inv load key", 80'(round_key_o), 80'(mk[79:16]));
      chk(round_num_o == 5'd31, "R2 inv load num", 80'(round_num_o), 80'd31);
      for (int r = 31; r >= 1; r--) begin
        mk = m_inv(mk, 5'(r));
        cyc(0, 1, ~t[1], '0);
        chk(round_key_o == mk[79:16], "R4 R8 inv round key", 80'(round_key_o), 80'(mk[79:16]));
        chk(round_num_o == 5'(r - 1), "R5 inv counter", 80'(round_num_o), 80'(5'(r - 1)));
      end
      chk(done_o, "R6 inv done", 80'(done_o), 80'd1);
      chk(round_key_o == orig[79:16] && mk == orig, "R7 key recovered", 80'(round_key_o), 80'(orig[79:16]));
    end

    orig = {$urandom, $urandom, 16'($urandom)};
    cyc(1, 0, 0, 80'h1);
    cyc(0, 1, 0, '0);
    cyc(1, 1, 0, orig);
    chk(round_key_o == orig[79:16] && round_num_o == 5'd1, "R9 load beats step", 80'(round_key_o), 80'(orig[79:16]));
    cyc(1, 1, 1, orig);
    chk(round_key_o == orig[79:16] && round_num_o == 5'd31, "R9 load beats step inv", 80'(round_num_o), 80'd31);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule